// File: doc/BRIEF.md
# Running-Priority Tracker with Split Completion

This block follows the running priority of a single processor interface to an interrupt controller. Each acknowledged interrupt pushes its priority and ID onto a small in-service stack. The running priority is the priority at the top of that stack, or all ones when nothing is in service. Lower numbers mean more urgent interrupts. The unit that picks which interrupt to acknowledge compares candidates against this value.

Completing an interrupt takes two actions. An end-of-interrupt strobe pops the stack and so lowers the running priority. A deactivate strobe clears the interrupt's active state. When the completion-mode input is 0, the end-of-interrupt strobe also deactivates the popped ID. When it is 1, the popped ID stays active and is marked as dropped until a deactivate strobe names it.

A deactivate strobe can carry a hardware-link flag and a physical ID. When it retires an active ID with the flag set, the block emits a one-cycle deactivation pulse carrying that physical ID toward the physical side. Without the flag, no pulse is emitted, and software must retire the physical interrupt itself. A deactivate strobe for an ID that is not active is ignored and sets a sticky error flag.

Top module: `prio_drop_unit`

## Requirements
- R1: After reset, runPrio is all ones, stackDepth is 0, activeVec and droppedVec are all zero, dirErr is 0 and physDeactValid is 0.
- R2: An accepted acknowledge (ackValid with ackId, ackPrio) makes runPrio equal ackPrio on the next cycle, increments stackDepth and sets activeVec[ackId].
- R3: An end-of-interrupt (eoiValid) with a non-empty stack pops it: runPrio returns to the priority of the entry below, or to all ones when the stack becomes empty.
- R4: With eoiModeSplit = 0, an end-of-interrupt also clears activeVec at the popped entry's ID.
- R5: With eoiModeSplit = 1, an end-of-interrupt leaves the popped ID's activeVec bit set and sets its droppedVec bit.
- R6: A deactivate strobe (dirValid, dirId) for an active ID clears both activeVec[dirId] and droppedVec[dirId] on the next cycle.
- R7: A deactivate strobe with dirHwLink = 1 that retires an active ID sets physDeactValid high for exactly one cycle, one cycle later, with physDeactId equal to dirPhysId.
- R8: A deactivate strobe with dirHwLink = 0 never causes a physDeactValid pulse.
- R9: A deactivate strobe for an ID whose activeVec bit is 0 changes no state and emits no pulse. It sets dirErr, which stays at 1 until reset.
- R10: An end-of-interrupt while stackDepth is 0 is ignored: stackDepth stays 0 and runPrio stays all ones.
- R11: An acknowledge while stackDepth equals DEPTH is ignored: depth, runPrio and activeVec are unchanged.
- R12: When ackValid and eoiValid arrive in the same cycle, the end-of-interrupt is processed and the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eoiModeSplit | input | 1 | 0: end-of-interrupt also deactivates; 1: separate deactivate needed |
| ackValid | input | 1 | Acknowledge strobe |
| ackId | input | ID_W | ID being acknowledged |
| ackPrio | input | PRIO_W | Priority of the acknowledged ID |
| eoiValid | input | 1 | End-of-interrupt strobe (priority drop) |
| dirValid | input | 1 | Deactivate strobe |
| dirId | input | ID_W | ID to deactivate |
| dirHwLink | input | 1 | Forward deactivation to physical side |
| dirPhysId | input | ID_W | Physical ID to forward |
| runPrio | output | PRIO_W | Current running priority (all ones when idle) |
| stackDepth | output | CNT_W | Number of in-service entries |
| activeVec | output | NUM_IDS | Active state per ID |
| droppedVec | output | NUM_IDS | Priority dropped, awaiting deactivation, per ID |
| physDeactValid | output | 1 | One-cycle physical deactivation pulse |
| physDeactId | output | ID_W | Physical ID carried by the pulse |
| dirErr | output | 1 | Sticky: deactivate for an inactive ID was seen |

## Verification
The hardest state to reach is a full in-service stack that then receives a further acknowledge. The bench gets there by issuing DEPTH nested acknowledges with distinct IDs and decreasing priority values before the extra one, then unwinds the stack entry by entry. The split-mode window is also hard to reach. In that window an ID has already released its priority but is still active, and the bench holds it there with an end-of-interrupt before it checks the hardware-linked and unlinked deactivations.

// File: rtl/prio_drop_pkg.sv
package prio_drop_pkg;
  typedef struct packed {
    logic push;       // accept acknowledge
    logic pop;        // accept end-of-interrupt
    logic eoiDeact;   // pop also retires active state
    logic eoiDrop;    // pop marks ID as dropped
    logic dirRetire;  // deactivate of an active ID
    logic dirBad;     // deactivate of an inactive ID
    logic cascade;    // forward deactivation to physical side
  } strobe_t;
endpackage

// File: rtl/prio_drop_ctrl.sv
module prio_drop_ctrl
  import prio_drop_pkg::*;
(
  input  logic    eoiModeSplit,
  input  logic    ackValid,
  input  logic    eoiValid,
  input  logic    dirValid,
  input  logic    dirHwLink,
  input  logic    stackEmpty,
  input  logic    stackFull,
  input  logic    dirActive,
  output strobe_t st
);
  always_comb begin
    st.push      = ackValid && !stackFull && !eoiValid;
    st.pop       = eoiValid && !stackEmpty;
    st.eoiDeact  = st.pop && !eoiModeSplit;
    st.eoiDrop   = st.pop && eoiModeSplit;
    st.dirRetire = dirValid && dirActive;
    st.dirBad    = dirValid && !dirActive;
    st.cascade   = st.dirRetire && dirHwLink;
  end
endmodule

// File: rtl/prio_drop_path.sv
module prio_drop_path
  import prio_drop_pkg::*;
#(
  parameter int NUM_IDS = 16,
  parameter int PRIO_W  = 8,
  parameter int DEPTH   = 8,
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
)(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [ID_W-1:0]    ackId,
  input  logic [PRIO_W-1:0]  ackPrio,
  input  logic [ID_W-1:0]    dirId,
  input  logic [ID_W-1:0]    dirPhysId,
  output logic [PRIO_W-1:0]  runPrio,
  output logic [CNT_W-1:0]   depth,
  output logic               stackEmpty,
  output logic               stackFull,
  output logic               dirActive,
  output logic [NUM_IDS-1:0] activeVec,
  output logic [NUM_IDS-1:0] droppedVec,
  output logic               physDeactValid,
  output logic [ID_W-1:0]    physDeactId,
  output logic               errFlag
);
  logic [PRIO_W-1:0]  prioMem [DEPTH];
  logic [ID_W-1:0]    idMem   [DEPTH];
  logic [PTR_W-1:0]   topIdx;
  logic [PTR_W-1:0]   wrIdx;
  logic [ID_W-1:0]    topId;
  logic [NUM_IDS-1:0] actNext;
  logic [NUM_IDS-1:0] dropNext;

  assign topIdx     = PTR_W'(depth - 1'b1);
  assign wrIdx      = PTR_W'(depth);
  assign topId      = idMem[topIdx];
  assign stackEmpty = (depth == '0);
  assign stackFull  = (depth == CNT_W'(DEPTH));
  assign runPrio    = stackEmpty ? '1 : prioMem[topIdx];
  assign dirActive  = activeVec[dirId];

  always_comb begin
    actNext  = activeVec;
    dropNext = droppedVec;
    if (st.eoiDeact) actNext[topId] = 1'b0;
    if (st.eoiDrop)  dropNext[topId] = 1'b1;
    if (st.dirRetire) begin
      actNext[dirId]  = 1'b0;
      dropNext[dirId] = 1'b0;
    end
    if (st.push) actNext[ackId] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth          <= '0;
      activeVec      <= '0;
      droppedVec     <= '0;
      physDeactValid <= 1'b0;
      physDeactId    <= '0;
      errFlag        <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        prioMem[i] <= '0;
        idMem[i]   <= '0;
      end
    end else begin
      activeVec      <= actNext;
      droppedVec     <= dropNext;
      physDeactValid <= st.cascade;
      if (st.cascade) physDeactId <= dirPhysId;
      if (st.dirBad) errFlag <= 1'b1;
      if (st.push) begin
        prioMem[wrIdx] <= ackPrio;
        idMem[wrIdx]   <= ackId;
        depth          <= depth + 1'b1;
      end else if (st.pop) begin
        depth <= depth - 1'b1;
      end
    end
  end

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    depth <= CNT_W'(DEPTH));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R3
  idle_after_last_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.pop && depth == CNT_W'(1)) |=> (runPrio == '1));

  // R2
  push_sets_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.push |=> activeVec[$past(ackId)]);
endmodule

// File: rtl/prio_drop_unit.sv
module prio_drop_unit
  import prio_drop_pkg::*;
#(
  parameter int NUM_IDS = 16,
  parameter int PRIO_W  = 8,
  parameter int DEPTH   = 8,
  localparam int ID_W   = $clog2(NUM_IDS),
  localparam int CNT_W  = $clog2(DEPTH + 1)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               eoiModeSplit,
  input  logic               ackValid,
  input  logic [ID_W-1:0]    ackId,
  input  logic [PRIO_W-1:0]  ackPrio,
  input  logic               eoiValid,
  input  logic               dirValid,
  input  logic [ID_W-1:0]    dirId,
  input  logic               dirHwLink,
  input  logic [ID_W-1:0]    dirPhysId,
  output logic [PRIO_W-1:0]  runPrio,
  output logic [CNT_W-1:0]   stackDepth,
  output logic [NUM_IDS-1:0] activeVec,
  output logic [NUM_IDS-1:0] droppedVec,
  output logic               physDeactValid,
  output logic [ID_W-1:0]    physDeactId,
  output logic               dirErr
);
  strobe_t st;
  logic stackEmpty, stackFull, dirActive;

  prio_drop_ctrl u_ctrl (
    .eoiModeSplit(eoiModeSplit), .ackValid(ackValid), .eoiValid(eoiValid),
    .dirValid(dirValid), .dirHwLink(dirHwLink), .stackEmpty(stackEmpty),
    .stackFull(stackFull), .dirActive(dirActive), .st(st)
  );

  prio_drop_path #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_path (
    .clk(clk), .rstN(rstN), .st(st), .ackId(ackId), .ackPrio(ackPrio),
    .dirId(dirId), .dirPhysId(dirPhysId), .runPrio(runPrio), .depth(stackDepth),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .dirActive(dirActive),
    .activeVec(activeVec), .droppedVec(droppedVec),
    .physDeactValid(physDeactValid), .physDeactId(physDeactId), .errFlag(dirErr)
  );

  // R7
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    physDeactValid |-> $past(dirValid && dirHwLink));

  // R8
  no_link_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirValid && !dirHwLink) |=> !physDeactValid);

  // R10
  empty_eoi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && stackDepth == '0) |=> (stackDepth == '0));

  // R5
  split_keeps_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && eoiModeSplit && stackDepth != '0 && !dirValid) |=> ($countones(activeVec) == $past($countones(activeVec))));
endmodule

// File: tb/prio_drop_unit_bench.sv
module prio_drop_unit_bench;
  localparam int NUM_IDS = 16;
  localparam int PRIO_W  = 8;
  localparam int DEPTH   = 8;
  localparam int ID_W    = $clog2(NUM_IDS);
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eoiModeSplit = 1'b0;
  logic ackValid = 1'b0;
  logic [ID_W-1:0] ackId = '0;
  logic [PRIO_W-1:0] ackPrio = '0;
  logic eoiValid = 1'b0;
  logic dirValid = 1'b0;
  logic [ID_W-1:0] dirId = '0;
  logic dirHwLink = 1'b0;
  logic [ID_W-1:0] dirPhysId = '0;
  logic [PRIO_W-1:0] runPrio;
  logic [CNT_W-1:0] stackDepth;
  logic [NUM_IDS-1:0] activeVec, droppedVec;
  logic physDeactValid;
  logic [ID_W-1:0] physDeactId;
  logic dirErr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  prio_drop_unit u_prio_drop_unit (
    .clk(clk), .rstN(rstN), .eoiModeSplit(eoiModeSplit), .ackValid(ackValid),
    .ackId(ackId), .ackPrio(ackPrio), .eoiValid(eoiValid), .dirValid(dirValid),
    .dirId(dirId), .dirHwLink(dirHwLink), .dirPhysId(dirPhysId),
    .runPrio(runPrio), .stackDepth(stackDepth), .activeVec(activeVec),
    .droppedVec(droppedVec), .physDeactValid(physDeactValid),
    .physDeactId(physDeactId), .dirErr(dirErr)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic doAck(int id, int prio);
    @(negedge clk); ackValid = 1'b1; ackId = ID_W'(id); ackPrio = PRIO_W'(prio);
    @(negedge clk); ackValid = 1'b0;
  endtask

  task automatic doEoi();
    @(negedge clk); eoiValid = 1'b1;
    @(negedge clk); eoiValid = 1'b0;
  endtask

  task automatic doDir(int id, bit link, int phys);
    @(negedge clk); dirValid = 1'b1; dirId = ID_W'(id); dirHwLink = link; dirPhysId = ID_W'(phys);
    @(negedge clk); dirValid = 1'b0; dirHwLink = 1'b0;
  endtask

  task automatic testReset();
    check("R1 runPrio", runPrio, 8'hff);
    check("R1 depth", stackDepth, 0);
    check("R1 active", activeVec, 0);
    check("R1 dropped", droppedVec, 0);
    check("R1 err", dirErr, 0);
    check("R1 pulse", physDeactValid, 0);
  endtask

  task automatic testMergedNesting();
    eoiModeSplit = 1'b0;
    doAck(3, 8'h40);
    check("R2 runPrio", runPrio, 8'h40);
    check("R2 active", activeVec, 16'h0008);
    doAck(5, 8'h20);
    check("R2 nested runPrio", runPrio, 8'h20);
    check("R2 depth", stackDepth, 2);
    doEoi();
    check("R3 pop runPrio", runPrio, 8'h40);
    check("R4 merged deact", activeVec, 16'h0008);
    check("R4 no dropped", droppedVec, 0);
    doEoi();
    check("R3 idle runPrio", runPrio, 8'hff);
    check("R4 all retired", activeVec, 0);
  endtask

  task automatic testSplitLinked();
    eoiModeSplit = 1'b1;
    doAck(7, 8'h10);
    doEoi();
    check("R3 split runPrio", runPrio, 8'hff);
    check("R5 still active", activeVec, 16'h0080);
    check("R5 dropped", droppedVec, 16'h0080);
    doDir(7, 1'b1, 8'h0a);
    check("R6 active cleared", activeVec, 0);
    check("R6 dropped cleared", droppedVec, 0);
    check("R7 pulse", physDeactValid, 1);
    check("R7 phys id", physDeactId, 4'ha);
    @(negedge clk);
    check("R7 one cycle", physDeactValid, 0);
  endtask

  task automatic testSplitUnlinked();
    eoiModeSplit = 1'b1;
    doAck(9, 8'h30);
    doEoi();
    check("R5 dropped 9", droppedVec, 16'h0200);
    doDir(9, 1'b0, 8'h03);
    check("R8 no pulse", physDeactValid, 0);
    check("R6 retired 9", activeVec, 0);
    @(negedge clk);
    check("R8 no late pulse", physDeactValid, 0);
  endtask

  task automatic testEmptyEoi();
    doEoi();
    check("R10 depth", stackDepth, 0);
    check("R10 runPrio", runPrio, 8'hff);
  endtask

  task automatic testFull();
    eoiModeSplit = 1'b0;
    for (int i = 0; i < DEPTH; i++) doAck(i, 8'h80 - i * 8);
    check("R11 filled", stackDepth, DEPTH);
    doAck(12, 8'h01);
    check("R11 depth held", stackDepth, DEPTH);
    check("R11 runPrio held", runPrio, 8'h80 - (DEPTH - 1) * 8);
    check("R11 active held", activeVec, 16'h00ff);
    for (int i = 0; i < DEPTH; i++) doEoi();
    check("R3 unwound", runPrio, 8'hff);
    check("R4 unwound", activeVec, 0);
  endtask

  task automatic testCollision();
    eoiModeSplit = 1'b0;
    doAck(2, 8'h50);
    @(negedge clk); ackValid = 1'b1; ackId = 4'd6; ackPrio = 8'h05; eoiValid = 1'b1;
    @(negedge clk); ackValid = 1'b0; eoiValid = 1'b0;
    check("R12 depth", stackDepth, 0);
    check("R12 runPrio", runPrio, 8'hff);
    check("R12 ack dropped", activeVec, 0);
  endtask

  task automatic testBadDir();
    doAck(1, 8'h60);
    doDir(4, 1'b1, 8'h04);
    check("R9 err", dirErr, 1);
    check("R9 no pulse", physDeactValid, 0);
    check("R9 active kept", activeVec, 16'h0002);
    check("R9 runPrio kept", runPrio, 8'h60);
    repeat (3) @(negedge clk);
    check("R9 sticky", dirErr, 1);
  endtask

  initial begin
    applyReset();
    @(negedge clk);
    testReset();
    testMergedNesting();
    testSplitLinked();
    testSplitUnlinked();
    testEmptyEoi();
    testFull();
    testCollision();
    testBadDir();
    applyReset();
    @(negedge clk);
    testReset();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule